// File: doc/BRIEF.md
# Clock Output Power Management Controller

This block decides, cycle by cycle, which parts of a multi-PLL clock generator are running and which clock outputs are driven. Two active-low control pins feed it through two-flop synchronizers: a combined shutdown/output-enable pin and a suspend pin. Static configuration bits set the meaning of each pin and which PLLs and outputs a suspend affects. The block produces a run enable for each PLL and for the reference oscillator, a drive enable for each configurable output, and a re-lock request. The PLLs, dividers and pull-down devices outside it are represented only by lock inputs, output clock levels and enable outputs.

A five-state machine holds the operating mode: `ST_RELOCK` (PLLs restarting, the reset state), `ST_RUN`, `ST_SUSPEND`, `ST_OE_OFF` (outputs off, everything still running) and `ST_SHUTDOWN` (everything stopped). Its transitions are: RELOCK→RUN or RELOCK→SUSPEND once every PLL reports lock; RUN→SUSPEND and SUSPEND→RUN as the suspend request rises and falls; any state except SHUTDOWN→SHUTDOWN when the shutdown pin is low in full-shutdown mode; RELOCK, RUN or SUSPEND→OE_OFF when it is low in output-enable mode; OE_OFF→SHUTDOWN if the mode becomes full shutdown while the pin is low; OE_OFF→RUN or OE_OFF→SUSPEND when the pin is released; SHUTDOWN→RELOCK when the pin is released. Each output selects its parent (reference or one PLL); an output is permitted only when its parent runs (and, for a PLL, reports lock), so a suspended PLL always takes its outputs with it. Each output's drive enable moves through a two-stage gate clocked by falling edges of that output's own clock. An always-on low-frequency clock passes straight through.

Top module: `clkpm_ctrl`

## Requirements
- R1: Right after reset the block is in the re-lock state: `relock_req_o`=1, all `pll_run_o` and `ref_osc_run_o` are 1, all `drive_en_o` are 0 and `fsel2_o` is 0 when suspend is enabled.
- R2: In output-enable mode (`cfg_sd_full_i`=0) a low `sd_oe_n_i` turns every drive enable off while all PLLs and the reference oscillator keep running; releasing the pin restores the outputs.
- R3: In full-shutdown mode (`cfg_sd_full_i`=1) a low `sd_oe_n_i` clears every `pll_run_o`, `ref_osc_run_o`, `relock_req_o` and drive enable.
- R4: Leaving shutdown enters re-lock: `relock_req_o`=1 and an output fed by PLL k stays off until `pll_lock_i[k]`=1, while reference-fed outputs come back at once; the request clears when all lock bits are 1.
- R5: With suspend enabled (`cfg_susp_en_i`=1) a low `susp_n_i` stops each PLL whose bit is set in `cfg_susp_pll_i` and turns off each output whose bit is set in `cfg_susp_out_i`; all other PLLs and outputs keep running.
- R6: An output whose source PLL is suspended is off even when its own suspend-mask bit is 0. Source select per output o is `cfg_src_sel_i[o*SEL_W +: SEL_W]`: 0 is the reference, k in 1..N_PLL is PLL k-1.
- R7: With suspend disabled (`cfg_susp_en_i`=0) the suspend pin has no effect on any enable, and `fsel2_o` equals its synchronized level; with suspend enabled `fsel2_o` is 0.
- R8: A low shutdown/OE pin takes priority over suspend: with both pins low the block is in shutdown or output-off, never suspend, and no suspend mask applies.
- R9: A drive enable changes only at a clock edge where that output's clock level is low, and takes a new requested value at the second falling edge of the output clock after the request changes.
- R10: `clk_out_o[o]` reads 0 whenever `drive_en_o[o]` is 0 (pulled low), and equals `oclk_i[o]` when it is 1.
- R11: `slow_clk_o` always equals `slow_clk_i`, in every state including shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_oe_n_i | input | 1 | Shutdown / output-enable pin, active low |
| susp_n_i | input | 1 | Suspend pin, active low (or frequency-select bit) |
| cfg_sd_full_i | input | 1 | 1: pin is full shutdown, 0: output enable only |
| cfg_susp_en_i | input | 1 | 1: suspend function enabled |
| cfg_susp_pll_i | input | N_PLL | PLLs stopped during suspend |
| cfg_susp_out_i | input | N_OUT | Outputs turned off during suspend |
| cfg_src_sel_i | input | N_OUT*SEL_W | Per-output source select |
| pll_lock_i | input | N_PLL | Lock status of each PLL |
| oclk_i | input | N_OUT | Level of each output's divided clock |
| slow_clk_i | input | 1 | Always-on low-frequency clock |
| pll_run_o | output | N_PLL | Run enable per PLL |
| ref_osc_run_o | output | 1 | Reference oscillator run enable |
| drive_en_o | output | N_OUT | Output drive enable |
| clk_out_o | output | N_OUT | Output pin level (low when not driven) |
| relock_req_o | output | 1 | PLLs must re-acquire lock |
| fsel2_o | output | 1 | Third frequency-select bit |
| slow_clk_o | output | 1 | Always-on clock output |

## Verification
A pin change reaches the state register after two synchronizer edges plus one, so `pll_run_o`, `ref_osc_run_o` and `relock_req_o` follow three control-clock edges later, and `fsel2_o` two edges later. A drive enable then needs two further falling edges of its own output clock, which runs with a four-cycle period in the table walk, so every table row waits 40 cycles before sampling all results together. The timing rule of R9 is checked separately with the output clocks held by hand: the bench produces one falling edge, confirms the enable has not yet moved, produces the second, and samples the enable and pin levels while the output clock is still low.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    typedef enum logic [2:0] {
        ST_RELOCK   = 3'd0,
        ST_RUN      = 3'd1,
        ST_SUSPEND  = 3'd2,
        ST_OE_OFF   = 3'd3,
        ST_SHUTDOWN = 3'd4
    } pm_state_e;

    // synchronizer depth for the asynchronous control pins
    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkpm_fsm.sv
module clkpm_fsm
    import clkpm_pkg::*;
#(
    parameter int N_PLL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_n_sync_i,
    input  logic             susp_n_sync_i,
    input  logic             cfg_full_i,
    input  logic             cfg_susp_en_i,
    input  logic [N_PLL-1:0] cfg_susp_pll_i,
    input  logic [N_PLL-1:0] pll_lock_i,
    output logic [N_PLL-1:0] pll_run_o,
    output logic             ref_run_o,
    output logic             out_allow_o,
    output logic             susp_on_o,
    output logic             relock_req_o
);

    pm_state_e state_q, state_d;
    logic      sd_low;
    logic      susp_act;
    logic      all_locked;

    assign sd_low     = ~sd_n_sync_i;
    assign susp_act   = cfg_susp_en_i & ~susp_n_sync_i;
    assign all_locked = &pll_lock_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RELOCK;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions; the shutdown/OE pin is tested first in every state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RELOCK: begin
                if (sd_low)          state_d = cfg_full_i ? ST_SHUTDOWN : ST_OE_OFF;
                else if (all_locked) state_d = susp_act ? ST_SUSPEND : ST_RUN;
            end
            ST_RUN: begin
                if (sd_low)        state_d = cfg_full_i ? ST_SHUTDOWN : ST_OE_OFF;
                else if (susp_act) state_d = ST_SUSPEND;
            end
            ST_SUSPEND: begin
                if (sd_low)         state_d = cfg_full_i ? ST_SHUTDOWN : ST_OE_OFF;
                else if (!susp_act) state_d = ST_RUN;
            end
            ST_OE_OFF: begin
                if (sd_low) begin
                    if (cfg_full_i) state_d = ST_SHUTDOWN;
                end else begin
                    state_d = susp_act ? ST_SUSPEND : ST_RUN;
                end
            end
            ST_SHUTDOWN: begin
                if (!sd_low) state_d = ST_RELOCK;
            end
            default: state_d = ST_RELOCK;
        endcase
    end

    // state decode to enables
    always_comb begin
        pll_run_o    = '1;
        ref_run_o    = 1'b1;
        out_allow_o  = 1'b0;
        susp_on_o    = 1'b0;
        relock_req_o = 1'b0;
        unique case (state_q)
            ST_RELOCK: begin
                out_allow_o  = 1'b1;
                relock_req_o = 1'b1;
            end
            ST_RUN: begin
                out_allow_o = 1'b1;
            end
            ST_SUSPEND: begin
                out_allow_o = 1'b1;
                susp_on_o   = 1'b1;
                pll_run_o   = ~cfg_susp_pll_i;
            end
            ST_OE_OFF: begin
                out_allow_o = 1'b0;
            end
            ST_SHUTDOWN: begin
                pll_run_o = '0;
                ref_run_o = 1'b0;
            end
            default: begin
                out_allow_o = 1'b0;
            end
        endcase
    end

    // R2: output-enable mode keeps every source running
    p_oe_keeps_plls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_low && !cfg_full_i && state_q != ST_SHUTDOWN)
        |=> (ref_run_o && pll_run_o == '1 && !out_allow_o));

    // R3: full shutdown stops all sources
    p_full_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_low && cfg_full_i) |=> (!ref_run_o && pll_run_o == '0));

    // R4: re-lock request held until every PLL reports lock
    p_relock_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELOCK && !sd_low && !all_locked) |=> relock_req_o);

    // R5: masked PLLs stop once suspend is taken
    p_susp_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN || state_q == ST_SUSPEND) && susp_act && !sd_low)
        |=> ((pll_run_o & $past(cfg_susp_pll_i)) == '0));

    // R8: shutdown/OE pin wins over suspend
    p_shut_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_low && susp_act) |=> !susp_on_o);

endmodule

// File: rtl/clkpm_out_gate.sv
module clkpm_out_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic oclk_lvl_i,
    output logic en_o,
    output logic pin_o
);

    logic prev_q;
    logic stage_q;
    logic en_q;
    logic fall;

    // a falling edge of the output clock is seen when it was high and is now low
    assign fall = prev_q & ~oclk_lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            stage_q <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            prev_q <= oclk_lvl_i;
            if (fall) begin
                stage_q <= want_i;
                en_q    <= stage_q;
            end
        end
    end

    assign en_o  = en_q;
    assign pin_o = en_q & oclk_lvl_i;

    // R9: the enable moves only at an edge where the output clock is low
    p_en_on_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != $past(en_q)) |-> !$past(oclk_lvl_i));

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
    import clkpm_pkg::*;
#(
    parameter int  N_PLL = 3,
    parameter int  N_OUT = 4,
    localparam int SEL_W = $clog2(N_PLL + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sd_oe_n_i,
    input  logic                   susp_n_i,
    input  logic                   cfg_sd_full_i,
    input  logic                   cfg_susp_en_i,
    input  logic [N_PLL-1:0]       cfg_susp_pll_i,
    input  logic [N_OUT-1:0]       cfg_susp_out_i,
    input  logic [N_OUT*SEL_W-1:0] cfg_src_sel_i,
    input  logic [N_PLL-1:0]       pll_lock_i,
    input  logic [N_OUT-1:0]       oclk_i,
    input  logic                   slow_clk_i,
    output logic [N_PLL-1:0]       pll_run_o,
    output logic                   ref_osc_run_o,
    output logic [N_OUT-1:0]       drive_en_o,
    output logic [N_OUT-1:0]       clk_out_o,
    output logic                   relock_req_o,
    output logic                   fsel2_o,
    output logic                   slow_clk_o
);

    logic             sd_n_sync;
    logic             susp_n_sync;
    logic             out_allow;
    logic             susp_on;
    logic [N_PLL-1:0] pll_run;
    logic             ref_run;
    logic [N_OUT-1:0] want;

    clkpm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sd (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sd_oe_n_i),
        .sync_o  (sd_n_sync)
    );

    clkpm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_susp (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (susp_n_i),
        .sync_o  (susp_n_sync)
    );

    clkpm_fsm #(.N_PLL(N_PLL)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sd_n_sync_i    (sd_n_sync),
        .susp_n_sync_i  (susp_n_sync),
        .cfg_full_i     (cfg_sd_full_i),
        .cfg_susp_en_i  (cfg_susp_en_i),
        .cfg_susp_pll_i (cfg_susp_pll_i),
        .pll_lock_i     (pll_lock_i),
        .pll_run_o      (pll_run),
        .ref_run_o      (ref_run),
        .out_allow_o    (out_allow),
        .susp_on_o      (susp_on),
        .relock_req_o   (relock_req_o)
    );

    generate
        for (genvar o = 0; o < N_OUT; o++) begin : g_out
            logic [SEL_W-1:0] src;
            logic             src_ok;

            assign src = cfg_src_sel_i[o*SEL_W +: SEL_W];

            // parent must run; a PLL parent must also be locked
            always_comb begin
                src_ok = 1'b0;
                if (src == '0) begin
                    src_ok = ref_run;
                end
                for (int p = 0; p < N_PLL; p++) begin
                    if (int'(src) == p + 1) begin
                        src_ok = pll_run[p] & pll_lock_i[p];
                    end
                end
            end

            assign want[o] = out_allow & src_ok & ~(susp_on & cfg_susp_out_i[o]);

            clkpm_out_gate u_gate (
                .clk        (clk),
                .rst_n      (rst_n),
                .want_i     (want[o]),
                .oclk_lvl_i (oclk_i[o]),
                .en_o       (drive_en_o[o]),
                .pin_o      (clk_out_o[o])
            );
        end
    endgenerate

    assign pll_run_o     = pll_run;
    assign ref_osc_run_o = ref_run;
    assign fsel2_o       = cfg_susp_en_i ? 1'b0 : susp_n_sync;
    assign slow_clk_o    = slow_clk_i;

endmodule

// File: tb/clkpm_ctrl_bench.sv
module clkpm_ctrl_bench;

    localparam int N_PLL = 3;
    localparam int N_OUT = 4;
    localparam int SEL_W = 2;
    localparam int NV    = 18;
    localparam int WD    = 100000;

    // row: full, susp_en, susp_pll[3], susp_out[4], sd_n, susp_n, lock[3] |
    //      exp_pll[3], exp_ref, exp_drv[4], exp_relock, exp_fsel
    localparam logic [23:0] VEC [NV] = '{
        {1'b1,1'b1,3'b000,4'b0000,1'b1,1'b1,3'b000, 3'b111,1'b1,4'b0001,1'b1,1'b0},
        {1'b1,1'b1,3'b000,4'b0000,1'b1,1'b1,3'b111, 3'b111,1'b1,4'b1111,1'b0,1'b0},
        {1'b0,1'b1,3'b000,4'b0000,1'b0,1'b1,3'b111, 3'b111,1'b1,4'b0000,1'b0,1'b0},
        {1'b0,1'b1,3'b000,4'b0000,1'b1,1'b1,3'b111, 3'b111,1'b1,4'b1111,1'b0,1'b0},
        {1'b1,1'b1,3'b000,4'b0000,1'b0,1'b1,3'b000, 3'b000,1'b0,4'b0000,1'b0,1'b0},
        {1'b1,1'b1,3'b000,4'b0000,1'b1,1'b1,3'b000, 3'b111,1'b1,4'b0001,1'b1,1'b0},
        {1'b1,1'b1,3'b000,4'b0000,1'b1,1'b1,3'b011, 3'b111,1'b1,4'b0111,1'b1,1'b0},
        {1'b1,1'b1,3'b000,4'b0000,1'b1,1'b1,3'b111, 3'b111,1'b1,4'b1111,1'b0,1'b0},
        {1'b1,1'b1,3'b001,4'b1000,1'b1,1'b0,3'b110, 3'b110,1'b1,4'b0101,1'b0,1'b0},
        {1'b1,1'b1,3'b001,4'b1000,1'b1,1'b1,3'b111, 3'b111,1'b1,4'b1111,1'b0,1'b0},
        {1'b1,1'b0,3'b111,4'b1111,1'b1,1'b0,3'b111, 3'b111,1'b1,4'b1111,1'b0,1'b0},
        {1'b1,1'b0,3'b111,4'b1111,1'b1,1'b1,3'b111, 3'b111,1'b1,4'b1111,1'b0,1'b1},
        {1'b1,1'b1,3'b001,4'b1000,1'b0,1'b0,3'b000, 3'b000,1'b0,4'b0000,1'b0,1'b0},
        {1'b1,1'b1,3'b001,4'b1000,1'b1,1'b0,3'b000, 3'b111,1'b1,4'b0001,1'b1,1'b0},
        {1'b1,1'b1,3'b001,4'b1000,1'b1,1'b0,3'b111, 3'b110,1'b1,4'b0101,1'b0,1'b0},
        {1'b1,1'b1,3'b001,4'b1000,1'b1,1'b1,3'b111, 3'b111,1'b1,4'b1111,1'b0,1'b0},
        {1'b0,1'b1,3'b001,4'b1000,1'b0,1'b0,3'b111, 3'b111,1'b1,4'b0000,1'b0,1'b0},
        {1'b0,1'b1,3'b001,4'b1000,1'b1,1'b1,3'b111, 3'b111,1'b1,4'b1111,1'b0,1'b0}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   sd_oe_n = 1'b1;
    logic                   susp_n = 1'b1;
    logic                   cfg_full = 1'b1;
    logic                   cfg_susp_en = 1'b1;
    logic [N_PLL-1:0]       cfg_susp_pll = '0;
    logic [N_OUT-1:0]       cfg_susp_out = '0;
    // out0 = reference, out1 = PLL0, out2 = PLL1, out3 = PLL2
    logic [N_OUT*SEL_W-1:0] cfg_src = 8'b11_10_01_00;
    logic [N_PLL-1:0]       pll_lock = '0;
    logic [N_OUT-1:0]       oclk;
    logic                   slow_clk = 1'b0;
    logic [N_PLL-1:0]       pll_run;
    logic                   ref_run;
    logic [N_OUT-1:0]       drive_en;
    logic [N_OUT-1:0]       clk_out;
    logic                   relock_req;
    logic                   fsel2;
    logic                   slow_out;

    logic                   free_run = 1'b1;
    logic                   tog = 1'b0;
    logic                   tcnt = 1'b0;
    logic [N_OUT-1:0]       man_lvl = '0;
    int                     n_cmp = 0;
    int                     n_bad = 0;
    int                     cyc = 0;

    assign oclk = free_run ? {N_OUT{tog}} : man_lvl;

    always #4 clk = ~clk;

    // free-running output clock, period four control cycles
    always @(negedge clk) begin
        tcnt <= ~tcnt;
        if (tcnt) tog <= ~tog;
    end

    clkpm_ctrl #(.N_PLL(N_PLL), .N_OUT(N_OUT)) u_clkpm_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .sd_oe_n_i      (sd_oe_n),
        .susp_n_i       (susp_n),
        .cfg_sd_full_i  (cfg_full),
        .cfg_susp_en_i  (cfg_susp_en),
        .cfg_susp_pll_i (cfg_susp_pll),
        .cfg_susp_out_i (cfg_susp_out),
        .cfg_src_sel_i  (cfg_src),
        .pll_lock_i     (pll_lock),
        .oclk_i         (oclk),
        .slow_clk_i     (slow_clk),
        .pll_run_o      (pll_run),
        .ref_osc_run_o  (ref_run),
        .drive_en_o     (drive_en),
        .clk_out_o      (clk_out),
        .relock_req_o   (relock_req),
        .fsel2_o        (fsel2),
        .slow_clk_o     (slow_out)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic string row_tag(input int idx);
        case (idx)
            0, 1, 5, 6, 7: row_tag = "R4";
            2, 3, 17:      row_tag = "R2";
            4:             row_tag = "R3";
            8:             row_tag = "R6";
            9, 14, 15:     row_tag = "R5";
            10, 11:        row_tag = "R7";
            default:       row_tag = "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        // R1: reset state
        chk(relock_req == 1'b1 && pll_run == 3'b111 && ref_run == 1'b1
            && drive_en == 4'b0000 && fsel2 == 1'b0, "R1", "reset state",
            {23'd0, relock_req, pll_run, ref_run, drive_en},
            {23'd0, 1'b1, 3'b111, 1'b1, 4'b0000});

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [23:0] r;
            logic [9:0]  got;
            r = VEC[v];
            cfg_full     = r[23];
            cfg_susp_en  = r[22];
            cfg_susp_pll = r[21:19];
            cfg_susp_out = r[18:15];
            sd_oe_n      = r[14];
            susp_n       = r[13];
            pll_lock     = r[12:10];
            wait_neg(40);
            got = {pll_run, ref_run, drive_en, relock_req, fsel2};
            chk(got == r[9:0], row_tag(v), $sformatf("row %0d {pll,ref,drv,relock,fsel}", v),
                {22'd0, got}, {22'd0, r[9:0]});
        end

        // R9 / R10: enable timing against the output's own clock
        free_run = 1'b0;
        man_lvl  = 4'b1111;
        wait_neg(4);
        cfg_full = 1'b0;
        sd_oe_n  = 1'b0;
        wait_neg(10);
        chk(drive_en == 4'b1111, "R9", "no output-clock fall yet", drive_en, 4'b1111);
        man_lvl = 4'b0000;
        wait_neg(2);
        man_lvl = 4'b1111;
        wait_neg(2);
        chk(drive_en == 4'b1111, "R9", "one fall only", drive_en, 4'b1111);
        chk(clk_out == 4'b1111, "R10", "driven pin follows clock", clk_out, 4'b1111);
        man_lvl = 4'b0000;
        wait_neg(2);
        chk(drive_en == 4'b0000, "R9", "second fall", drive_en, 4'b0000);
        man_lvl = 4'b1111;
        wait_neg(3);
        chk(clk_out == 4'b0000, "R10", "undriven pin reads low", clk_out, 4'b0000);
        chk(pll_run == 3'b111 && ref_run == 1'b1, "R2", "sources run with outputs off",
            {pll_run, ref_run}, 4'b1111);

        // R11: always-on clock in full shutdown
        free_run = 1'b1;
        cfg_full = 1'b1;
        wait_neg(20);
        slow_clk = 1'b1;
        wait_neg(1);
        chk(slow_out == 1'b1 && ref_run == 1'b0, "R11", "slow clock high in shutdown",
            {slow_out, ref_run}, 2'b10);
        slow_clk = 1'b0;
        wait_neg(1);
        chk(slow_out == 1'b0, "R11", "slow clock low in shutdown", slow_out, 1'b0);

        finish_run();
    end

endmodule